// File: doc/BRIEF.md
# Serial Register Access Bridge

This block lets an external serial master read and write a bank of 198 byte-wide configuration registers. The serial clock, select and data lines are brought into the system clock domain through two-flop synchronizers. Edge detection then turns the serial clock into single-cycle rise and fall events. A transaction sends a command byte, then a register address byte, then any number of data bytes, all most significant bit first. Input bits are taken on rising serial clock edges. Read data is launched on falling edges.

While select stays low, each further data byte goes to the next register. The address counter steps to zero after register 197, so a single command can cover the whole bank from any starting point. Writes leave the block as a one-cycle strobe with address and data. A small register file in the top consumes them and serves reads. That file accepts a write on every cycle, so the write path has no ready signal and no back-pressure. Raising select ends the transaction at any point. A byte that is only partly shifted in when select rises is discarded.

Top module: `spi_regbridge`

## Requirements
- R1: After reset, `spi_miso_oe`, `spi_miso` and `wr_stb` are 0, and register n holds n XOR 8'h5A.
- R2: Command 8'h02, an address byte and one data byte produce exactly one `wr_stb` pulse carrying that address and data, and the register then holds the data.
- R3: Command 8'h03 and an address byte cause the addressed register to be shifted out on `spi_miso`, most significant bit first. Each bit changes after a falling serial clock edge and is valid at the next rising edge.
- R4: In a write burst, each further data byte sent while select stays low is written to the address one above the previous one.
- R5: In a read burst, each further byte shifted out while select stays low comes from the address one above the previous one.
- R6: After register 197 the address counter continues at 0, for both reads and writes, and no strobe ever carries an address above 197.
- R7: A command byte other than 8'h02 or 8'h03 is ignored. No strobe occurs, no register changes, and `spi_miso` stays 0 until select goes high.
- R8: Select going high at any point aborts the transaction. A partly received byte is discarded, and the next transaction starts again with a command byte.
- R9: While select is high, `spi_miso_oe` and `spi_miso` are 0. While select is low, `spi_miso_oe` is 1.
- R10: A start address above 197 is treated as address 0.
- R11: Each write strobe lasts exactly one system clock cycle, one per completed write data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master, idle low |
| spi_cs_n | input | 1 | Active-low select from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for the serial data pad |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Register address of the write |
| wr_data | output | 8 | Data of the write |

## Verification
Two things can happen in the same system clock cycle. A write data byte at register 197 completes, which raises the strobe for address 197, and in that same cycle the address counter steps back to 0. A write burst started at 196 provokes this. The scoreboard expects strobes at 196, 197 and then 0 in that order, and a read burst across the same boundary must return the written values in the same wrapped order. A full-bank read started at 100 exercises the wrap on the read side, where the counter step and the fetch of register 0 coincide.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  typedef enum logic [1:0] {
    ST_CMD    = 2'd0,
    ST_ADDR   = 2'd1,
    ST_DATA   = 2'd2,
    ST_IGNORE = 2'd3
  } rb_state_e;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_n_s,
  output logic mosi_s
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] sclk_p, cs_p, mosi_p;
  logic              sclk_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p    <= '0;
      cs_p      <= '1;
      mosi_p    <= '0;
      sclk_last <= 1'b0;
    end else begin
      sclk_p    <= {sclk_p[TOP-1:0], sclk_i};
      cs_p      <= {cs_p[TOP-1:0], cs_n_i};
      mosi_p    <= {mosi_p[TOP-1:0], mosi_i};
      sclk_last <= sclk_p[TOP];
    end
  end

  assign sclk_rise = sclk_p[TOP] & ~sclk_last;
  assign sclk_fall = ~sclk_p[TOP] & sclk_last;
  assign cs_n_s    = cs_p[TOP];
  assign mosi_s    = mosi_p[TOP];
endmodule

// File: rtl/spi_rb_proto.sv
module spi_rb_proto
  import spi_rb_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter int                ADDR_W   = 8,
  parameter int                NUM_REGS = 198,
  parameter logic [DATA_W-1:0] CMD_RD   = 8'h03,
  parameter logic [DATA_W-1:0] CMD_WR   = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi_s,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              miso_q
);
  localparam int                CNT_W     = $clog2(DATA_W);
  localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(DATA_W - 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);
  localparam logic [DATA_W-1:0] REGS_B    = DATA_W'(NUM_REGS);

  rb_state_e         st;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] rx_sh, tx_sh;
  logic [ADDR_W-1:0] addr;
  logic              is_rd;

  logic [DATA_W-1:0] rx_byte;
  logic              byte_done;
  logic [ADDR_W-1:0] addr_inc, start_addr;

  assign rx_byte    = {rx_sh[DATA_W-2:0], mosi_s};
  assign byte_done  = sclk_rise && (bit_cnt == LAST_BIT);
  assign addr_inc   = (addr == LAST_ADDR) ? '0 : addr + 1'b1;
  assign start_addr = (rx_byte < REGS_B) ? ADDR_W'(rx_byte) : '0;
  assign rd_addr    = (st == ST_ADDR) ? start_addr : addr_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_CMD;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      addr    <= '0;
      is_rd   <= 1'b0;
      miso_q  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else if (cs_n_s) begin
      st      <= ST_CMD;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      is_rd   <= 1'b0;
      miso_q  <= 1'b0;
      wr_stb  <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (sclk_rise) begin
        bit_cnt <= bit_cnt + 1'b1;
        rx_sh   <= rx_byte;
      end
      if (byte_done) begin
        unique case (st)
          ST_CMD: begin
            if (rx_byte == CMD_RD) begin
              st    <= ST_ADDR;
              is_rd <= 1'b1;
            end else if (rx_byte == CMD_WR) begin
              st    <= ST_ADDR;
              is_rd <= 1'b0;
            end else begin
              st <= ST_IGNORE;
            end
          end
          ST_ADDR: begin
            st   <= ST_DATA;
            addr <= start_addr;
            if (is_rd) tx_sh <= rd_data;
          end
          ST_DATA: begin
            addr <= addr_inc;
            if (is_rd) begin
              tx_sh <= rd_data;
            end else begin
              wr_stb  <= 1'b1;
              wr_addr <= addr;
              wr_data <= rx_byte;
            end
          end
          default: st <= ST_IGNORE;
        endcase
      end
      if (sclk_fall && st == ST_DATA && is_rd) begin
        miso_q <= tx_sh[DATA_W-1];
        tx_sh  <= {tx_sh[DATA_W-2:0], 1'b0};
      end
    end
  end

  // R11
  wr_stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R2
  wr_stb_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ($past(st) == ST_DATA && !$past(is_rd)));

  // R8
  cs_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (st == ST_CMD && bit_cnt == '0 && !wr_stb));

  // R7
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IGNORE) |-> (!miso_q && !wr_stb));

  // R6
  addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_s && byte_done && st == ST_DATA && addr == LAST_ADDR) |=> (addr == '0));
endmodule

// File: rtl/spi_rb_regfile.sv
module spi_rb_regfile #(
  parameter int                DATA_W   = 8,
  parameter int                ADDR_W   = 8,
  parameter int                NUM_REGS = 198,
  parameter logic [DATA_W-1:0] RST_XOR  = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] REGS_A = ADDR_W'(NUM_REGS);

  logic [DATA_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= DATA_W'(i) ^ RST_XOR;
    end else if (wr_stb && wr_addr < REGS_A) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = (rd_addr < REGS_A) ? mem[rd_addr] : '0;

  // R6
  wr_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (wr_addr < REGS_A));
endmodule

// File: rtl/spi_regbridge.sv
module spi_regbridge #(
  parameter int        DATA_W   = 8,
  parameter int        NUM_REGS = 198,
  parameter int        STAGES   = 2,
  parameter logic [7:0] CMD_RD  = 8'h03,
  parameter logic [7:0] CMD_WR  = 8'h02,
  parameter logic [7:0] RST_XOR = 8'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sclk,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic       spi_miso_oe,
  output logic       wr_stb,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data
);
  localparam int ADDR_W = 8;

  logic              sclk_rise, sclk_fall, cs_n_s, mosi_s, miso_q;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;

  spi_rb_sync #(.STAGES(STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_i    (spi_sclk),
    .cs_n_i    (spi_cs_n),
    .mosi_i    (spi_mosi),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_n_s    (cs_n_s),
    .mosi_s    (mosi_s)
  );

  spi_rb_proto #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS),
    .CMD_RD   (CMD_RD),
    .CMD_WR   (CMD_WR)
  ) u_proto (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_s    (cs_n_s),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .mosi_s    (mosi_s),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .miso_q    (miso_q)
  );

  spi_rb_regfile #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS),
    .RST_XOR  (RST_XOR)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign spi_miso_oe = ~cs_n_s;
  assign spi_miso    = miso_q & ~cs_n_s;

  // R9
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_miso_oe |-> !spi_miso);
endmodule

// File: tb/tb_spi_regbridge.sv
module tb_spi_regbridge;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sclk = 1'b0;
  logic       spi_cs_n = 1'b1;
  logic       spi_mosi = 1'b0;
  logic       spi_miso, spi_miso_oe, wr_stb;
  logic [7:0] wr_addr, wr_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0]  model [198];
  logic [15:0] exp_q [$];

  always #2 clk = ~clk;

  spi_regbridge dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: write strobes against expected queue (R2 R4 R6 R11)
  logic prev_stb = 1'b0;
  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected strobe", {wr_addr, wr_data}, 16'h0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check({wr_addr, wr_data} == e, "R2 strobe addr/data", {wr_addr, wr_data}, e);
      end
      check(!prev_stb, "R11 strobe width", {15'd0, prev_stb}, 16'h0);
    end
    prev_stb = wr_stb;
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bit(input logic b, output logic r);
    spi_mosi = b;
    wait_n(8);
    r = spi_miso;
    spi_sclk = 1'b1;
    wait_n(8);
    spi_sclk = 1'b0;
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic r;
      spi_bit(tx[i], r);
      rx[i] = r;
    end
  endtask

  task automatic cs_begin();
    spi_cs_n = 1'b0;
    wait_n(8);
    check(spi_miso_oe == 1'b1, "R9 oe while selected", {15'd0, spi_miso_oe}, 16'h1);
  endtask

  task automatic cs_end();
    wait_n(8);
    spi_cs_n = 1'b1;
    wait_n(10);
    check(spi_miso_oe == 1'b0 && spi_miso == 1'b0, "R9 idle output",
          {14'd0, spi_miso_oe, spi_miso}, 16'h0);
  endtask

  function automatic logic [7:0] nxt(input logic [7:0] a);
    return (a == 8'd197) ? 8'd0 : a + 8'd1;
  endfunction

  task automatic write_burst(input logic [7:0] start, input int n, input logic [7:0] seed, input string req);
    logic [7:0] a, rx;
    a = (start > 8'd197) ? 8'd0 : start;
    cs_begin();
    spi_byte(8'h02, rx);
    spi_byte(start, rx);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = seed + 8'(i * 37);
      exp_q.push_back({a, d});
      model[a] = d;
      spi_byte(d, rx);
      a = nxt(a);
    end
    cs_end();
    check(exp_q.size() == 0, req, 16'(exp_q.size()), 16'h0);
  endtask

  task automatic read_burst(input logic [7:0] start, input int n, input string req);
    logic [7:0] a, rx;
    a = (start > 8'd197) ? 8'd0 : start;
    cs_begin();
    spi_byte(8'h03, rx);
    spi_byte(start, rx);
    for (int i = 0; i < n; i++) begin
      spi_byte(8'hFF, rx);
      check(rx == model[a], req, {a, rx}, {a, model[a]});
      a = nxt(a);
    end
    cs_end();
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 16'h0, 16'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    for (int i = 0; i < 198; i++) model[i] = 8'(i) ^ 8'h5A;
    wait_n(5);
    // R1 reset state
    check(spi_miso_oe == 1'b0 && spi_miso == 1'b0 && wr_stb == 1'b0, "R1 outputs in reset",
          {13'd0, spi_miso_oe, spi_miso, wr_stb}, 16'h0);
    rst_n = 1'b1;
    wait_n(5);
    check(spi_miso_oe == 1'b0 && wr_stb == 1'b0, "R1 outputs after reset",
          {14'd0, spi_miso_oe, wr_stb}, 16'h0);

    // R1 R3 R5: reset contents through a read burst
    read_burst(8'd10, 3, "R3 R5 read of reset contents");
    // R2 single write then read
    write_burst(8'd5, 1, 8'hC3, "R2 single write drained");
    read_burst(8'd5, 1, "R2 readback");
    // R4 write burst, R5 read burst
    write_burst(8'd50, 4, 8'h11, "R4 write burst drained");
    read_burst(8'd49, 6, "R4 R5 burst readback");
    // R6 wrap on write and read; strobe and wrap coincide
    write_burst(8'd196, 3, 8'h80, "R6 wrap write drained");
    read_burst(8'd195, 5, "R6 wrap readback");
    // R10 out-of-range start address
    read_burst(8'd250, 2, "R10 read start above range");
    write_burst(8'd220, 1, 8'h3C, "R10 write start above range");
    read_burst(8'd0, 1, "R10 readback of reg 0");

    // R7 unknown command: miso held 0, no strobe, contents kept
    cs_begin();
    spi_byte(8'h07, rx);
    spi_byte(8'd60, rx);
    check(rx == 8'h00, "R7 miso during address", {8'd0, rx}, 16'h0);
    spi_byte(8'hAA, rx);
    check(rx == 8'h00, "R7 miso during data", {8'd0, rx}, 16'h0);
    cs_end();
    read_burst(8'd60, 1, "R7 register untouched");

    // R8 abort inside a write data byte
    cs_begin();
    spi_byte(8'h02, rx);
    spi_byte(8'd30, rx);
    for (int i = 0; i < 4; i++) begin
      logic r;
      spi_bit(1'b1, r);
    end
    cs_end();
    read_burst(8'd30, 1, "R8 partial byte discarded");
    // R8 abort inside a command byte, then a fresh write works
    cs_begin();
    for (int i = 0; i < 5; i++) begin
      logic r;
      spi_bit(1'b0, r);
    end
    cs_end();
    write_burst(8'd31, 1, 8'h9E, "R8 fresh transaction after abort");
    read_burst(8'd31, 1, "R8 readback after abort");

    // R6 R5 full-bank read from the middle
    read_burst(8'd100, 198, "R6 full bank wrap read");

    wait_n(10);
    check(exp_q.size() == 0, "R2 scoreboard empty", 16'(exp_q.size()), 16'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule